// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-relative reference into a physical address. Each request names one of a small number of segments through a selector and gives an offset within that segment, along with the kind of access wanted: a data read, a data write or an instruction fetch. The selector picks a descriptor from an on-chip table. The descriptor supplies the segment's starting physical address, its highest legal offset and a set of permission bits.

The offset is added to the segment start to form the physical address. In the same cycle, the offset is compared against the segment limit and the access kind is checked against the permissions. A request that breaks either rule returns a fault with a cause code instead of an address.

System software fills the table through a separate write port. Giving each process its own table contents keeps its segments private. Each result is registered, so it appears one cycle after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rspValid` and `rspFault` are low, and every descriptor is cleared to start 0, limit 0 and no permissions. A read at offset 0 of any selector therefore faults with cause 1.
- R2: A request presented with `lkValid` high at a clock edge produces `rspValid` high during the next cycle only. When no request is presented, `rspValid` stays low in the following cycle.
- R3: A request that is not faulted returns `rspAddr` equal to the segment start plus the zero-extended offset, modulo 2^32, with `rspFault` low and `rspCause` 0.
- R4: An offset strictly greater than the segment limit raises `rspFault` with `rspCause` 0 (limit violation), and `rspAddr` reads 0.
- R5: An offset exactly equal to the segment limit is in range and does not cause a limit violation.
- R6: The permission bits are bit 0 for read, bit 1 for write and bit 2 for execute. `lkType` is 0 for read, 1 for write and 2 for fetch. An in-range request whose matching permission bit is 0 raises `rspFault` with `rspCause` 1 and `rspAddr` 0.
- R7: `lkType` value 3 is reserved. An in-range request of that type always faults with `rspCause` 1.
- R8: When a request breaks both the limit and the permissions, the reported cause is 0.
- R9: A descriptor write and a request on the same selector in the same cycle give a result based on the old descriptor. The next request sees the new one.
- R10: A descriptor write changes only the entry named by `wrSel`. The other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load a descriptor this cycle |
| wrSel | input | 3 | Entry to load |
| wrBase | input | 32 | Segment start address to store |
| wrBound | input | 20 | Highest legal offset to store |
| wrRights | input | 3 | Permission bits to store (bit0 read, bit1 write, bit2 execute) |
| lkValid | input | 1 | Translation request strobe |
| lkSel | input | 3 | Segment selector of the request |
| lkOffset | input | 20 | Offset within the segment |
| lkType | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rspValid | output | 1 | Result strobe, one cycle after the request |
| rspFault | output | 1 | Request refused |
| rspCause | output | 1 | Fault cause: 0 limit, 1 permission |
| rspAddr | output | 32 | Physical address, 0 when faulted or idle |

## Verification
The latency properties compare each cycle's result strobe with the request strobe one cycle earlier. They assume `lkValid` is held low while reset is asserted, and the bench drives it low from time zero through reset. The limit and permission properties assume the request fields are stable across the sampling edge. The bench changes every input only on the falling clock edge. It sweeps every selector, every access kind and every permission pattern, using offsets at zero, mid-range, exactly the limit, one past it and the largest offset. It uses one segment whose start lies near the top of the address space so that the sum wraps.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int RIGHTS_W    = 3;
  localparam int RIGHT_READ  = 0;
  localparam int RIGHT_WRITE = 1;
  localparam int RIGHT_EXEC  = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accType_t;

  typedef enum logic {
    CAUSE_BOUND  = 1'b0,
    CAUSE_RIGHTS = 1'b1
  } faultCause_t;

  typedef struct packed {
    logic                tblWr;
    logic                capture;
    logic [RIGHTS_W-1:0] needMask;
    logic                badType;
  } xlateStrobes_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          lkValid,
  input  logic [1:0]    lkType,
  output xlateStrobes_t strobes
);

  logic [RIGHTS_W-1:0] maskDec;
  logic                rsvdType;

  always_comb begin
    maskDec  = '0;
    rsvdType = 1'b0;
    case (accType_t'(lkType))
      ACC_READ:  maskDec[RIGHT_READ]  = 1'b1;
      ACC_WRITE: maskDec[RIGHT_WRITE] = 1'b1;
      ACC_FETCH: maskDec[RIGHT_EXEC]  = 1'b1;
      default:   rsvdType = 1'b1;
    endcase
  end

  always_comb begin
    strobes.tblWr    = wrEn;
    strobes.capture  = lkValid;
    strobes.needMask = maskDec;
    strobes.badType  = rsvdType;
  end

  AST_MASK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> ($onehot(strobes.needMask) != strobes.badType)); // R6

  AST_RSVD_NO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && lkType == 2'd3) |-> (strobes.needMask == '0)); // R7

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int BASE_W = 32,
  parameter int OFF_W  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlateStrobes_t       strobes,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic [BASE_W-1:0]   wrBase,
  input  logic [OFF_W-1:0]    wrBound,
  input  logic [RIGHTS_W-1:0] wrRights,
  input  logic [SEL_W-1:0]    lkSel,
  input  logic [OFF_W-1:0]    lkOffset,
  output logic                rspValid,
  output logic                rspFault,
  output logic                rspCause,
  output logic [BASE_W-1:0]   rspAddr
);

  localparam int ENTRIES = 1 << SEL_W;

  typedef struct packed {
    logic [BASE_W-1:0]   segStart;
    logic [OFF_W-1:0]    segLimit;
    logic [RIGHTS_W-1:0] segRights;
  } desc_t;

  desc_t descTbl [ENTRIES];
  desc_t selDesc;

  logic              overBound;
  logic              rightsDenied;
  logic              anyFault;
  logic [BASE_W-1:0] sumAddr;

  // Table: reads see the contents before this edge's write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) descTbl[e] <= '0;
    end else if (strobes.tblWr) begin
      descTbl[wrSel] <= '{segStart: wrBase, segLimit: wrBound, segRights: wrRights};
    end
  end

  assign selDesc      = descTbl[lkSel];
  assign overBound    = lkOffset > selDesc.segLimit;
  assign rightsDenied = strobes.badType || ((strobes.needMask & selDesc.segRights) == '0);
  assign anyFault     = overBound || rightsDenied;
  assign sumAddr      = selDesc.segStart + BASE_W'(lkOffset);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCause <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspFault <= anyFault;
        rspCause <= overBound ? CAUSE_BOUND : (rightsDenied ? CAUSE_RIGHTS : 1'b0);
        rspAddr  <= anyFault ? '0 : sumAddr;
      end else begin
        rspFault <= 1'b0;
        rspCause <= 1'b0;
        rspAddr  <= '0;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rspValid == $past(strobes.capture))); // R2

  AST_BOUND_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.capture) && $past(overBound)) |-> (rspFault && rspCause == CAUSE_BOUND)); // R4

  AST_LIMIT_INCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strobes.capture) && $past(lkOffset == selDesc.segLimit))
      |-> !(rspFault && rspCause == CAUSE_BOUND)); // R5

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspValid && rspAddr == '0)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspFault && rspCause == 1'b0)); // R1

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int BASE_W = 32,
  parameter int OFF_W  = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic [BASE_W-1:0]   wrBase,
  input  logic [OFF_W-1:0]    wrBound,
  input  logic [RIGHTS_W-1:0] wrRights,
  input  logic                lkValid,
  input  logic [SEL_W-1:0]    lkSel,
  input  logic [OFF_W-1:0]    lkOffset,
  input  logic [1:0]          lkType,
  output logic                rspValid,
  output logic                rspFault,
  output logic                rspCause,
  output logic [BASE_W-1:0]   rspAddr
);

  xlateStrobes_t strobes;

  seg_xlate_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .lkValid (lkValid),
    .lkType  (lkType),
    .strobes (strobes)
  );

  seg_xlate_dp #(
    .SEL_W  (SEL_W),
    .BASE_W (BASE_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrSel    (wrSel),
    .wrBase   (wrBase),
    .wrBound  (wrBound),
    .wrRights (wrRights),
    .lkSel    (lkSel),
    .lkOffset (lkOffset),
    .rspValid (rspValid),
    .rspFault (rspFault),
    .rspCause (rspCause),
    .rspAddr  (rspAddr)
  );

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrBase = '0;
  logic [19:0] wrBound = '0;
  logic [2:0]  wrRights = '0;
  logic        lkValid = 1'b0;
  logic [2:0]  lkSel = '0;
  logic [19:0] lkOffset = '0;
  logic [1:0]  lkType = '0;
  logic        rspValid, rspFault, rspCause;
  logic [31:0] rspAddr;

  int testsRun = 0;
  int testsFailed = 0;
  bit summaryDone = 0;

  logic [31:0] mBase [8];
  logic [19:0] mBound [8];
  logic [2:0]  mRights [8];

  always #2 clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSel(wrSel), .wrBase(wrBase), .wrBound(wrBound), .wrRights(wrRights),
    .lkValid(lkValid), .lkSel(lkSel), .lkOffset(lkOffset), .lkType(lkType),
    .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause), .rspAddr(rspAddr)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  task automatic writeDesc(input logic [2:0] s, input logic [31:0] b, input logic [19:0] l, input logic [2:0] r);
    @(negedge clk);
    wrEn = 1; wrSel = s; wrBase = b; wrBound = l; wrRights = r;
    @(negedge clk);
    wrEn = 0;
    mBase[s] = b; mBound[s] = l; mRights[s] = r;
  endtask

  // Expected result from the model: {valid, fault, cause, addr}
  function automatic logic [34:0] predict(input logic [2:0] s, input logic [19:0] off, input logic [1:0] t);
    if (off > mBound[s]) return {1'b1, 1'b1, 1'b0, 32'h0};
    if (t == 2'd3 || !mRights[s][t]) return {1'b1, 1'b1, 1'b1, 32'h0};
    return {1'b1, 1'b0, 1'b0, mBase[s] + {12'h0, off}};
  endfunction

  function automatic string tagFor(input logic [2:0] s, input logic [19:0] off, input logic [1:0] t);
    bit rightsBad = (t == 2'd3) || !mRights[s][t];
    if (off > mBound[s] && rightsBad) return "R8";
    if (off > mBound[s]) return "R4";
    if (t == 2'd3) return "R7";
    if (rightsBad) return "R6";
    if (off == mBound[s]) return "R5";
    return "R3";
  endfunction

  task automatic lookupCheck(input logic [2:0] s, input logic [19:0] off, input logic [1:0] t,
                             input logic [34:0] exp, input string req);
    logic [34:0] got;
    @(negedge clk);
    lkValid = 1; lkSel = s; lkOffset = off; lkType = t;
    @(negedge clk);
    lkValid = 0;
    got = {rspValid, rspFault, rspCause, rspAddr};
    check(got == exp, req, {1'b0, got}, {1'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mBase[i] = '0; mBound[i] = '0; mRights[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!rspValid && !rspFault, "R1 during reset", {34'h0, rspValid, rspFault}, 36'h0);
    rstN = 1;
    @(negedge clk);
    check(!rspValid && !rspFault, "R1 after reset", {34'h0, rspValid, rspFault}, 36'h0);
    // R1: cleared table gives a permission fault at offset 0
    for (int s = 0; s < 8; s++)
      lookupCheck(3'(s), 20'h0, 2'd0, {1'b1, 1'b1, 1'b1, 32'h0}, "R1 cleared entry");

    // R2: no request -> no strobe in the following cycle
    @(negedge clk);
    check(!rspValid, "R2 idle strobe", {35'h0, rspValid}, 36'h0);

    // Load all entries; rights pattern equals selector, covering all 8 combinations
    for (int s = 0; s < 8; s++) begin
      logic [31:0] b;
      logic [19:0] l;
      b = (s == 7) ? 32'hFFFF_F800 : (32'h1000_0000 * s + 32'h0000_0400 * s + 32'h0000_0123);
      l = (s == 5) ? 20'hFFFFF : (20'h00100 * (s + 1) + 20'(s));
      writeDesc(3'(s), b, l, 3'(s));
    end

    // Sweep all selectors, access kinds and edge offsets (R3..R8)
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 4; t++) begin
        for (int k = 0; k < 5; k++) begin
          logic [19:0] off;
          case (k)
            0: off = 20'h0;
            1: off = mBound[s] >> 1;
            2: off = mBound[s];
            3: off = (mBound[s] == 20'hFFFFF) ? 20'h7FFFF : mBound[s] + 20'h1;
            default: off = 20'hFFFFF;
          endcase
          lookupCheck(3'(s), off, 2'(t), predict(3'(s), off, 2'(t)), tagFor(3'(s), off, 2'(t)));
        end
      end
    end

    // R3: wrap of the sum past 2^32 on entry 7 (read permitted via bit0)
    writeDesc(3'd7, 32'hFFFF_F800, 20'h01000, 3'b001);
    lookupCheck(3'd7, 20'h00C00, 2'd0, {1'b1, 1'b0, 1'b0, 32'h0000_0400}, "R3 wrap");

    // R2: back-to-back style: strobe drops one cycle after a request
    lookupCheck(3'd6, 20'h0, 2'd1, predict(3'd6, 20'h0, 2'd1), "R2 request");
    @(negedge clk);
    check(!rspValid, "R2 strobe single cycle", {35'h0, rspValid}, 36'h0);

    // R9: same-cycle write and lookup on entry 4
    begin
      logic [34:0] oldExp;
      logic [34:0] got;
      oldExp = predict(3'd4, 20'h00010, 2'd1);
      @(negedge clk);
      wrEn = 1; wrSel = 3'd4; wrBase = 32'hABCD_0000; wrBound = 20'h00020; wrRights = 3'b010;
      lkValid = 1; lkSel = 3'd4; lkOffset = 20'h00010; lkType = 2'd1;
      @(negedge clk);
      wrEn = 0; lkValid = 0;
      got = {rspValid, rspFault, rspCause, rspAddr};
      check(got == oldExp, "R9 old descriptor", {1'b0, got}, {1'b0, oldExp});
      mBase[4] = 32'hABCD_0000; mBound[4] = 20'h00020; mRights[4] = 3'b010;
    end
    lookupCheck(3'd4, 20'h00010, 2'd1, {1'b1, 1'b0, 1'b0, 32'hABCD_0010}, "R9 new descriptor");
    lookupCheck(3'd4, 20'h00021, 2'd1, {1'b1, 1'b1, 1'b0, 32'h0}, "R9 new limit");

    // R10: neighbours untouched by the write
    lookupCheck(3'd3, 20'h00010, 2'd0, predict(3'd3, 20'h00010, 2'd0), "R10 neighbour below");
    lookupCheck(3'd5, 20'h00010, 2'd0, predict(3'd5, 20'h00010, 2'd0), "R10 neighbour above");

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule